// File: doc/BRIEF.md
# Write Leveling Calibration Controller

This block finds the write-strobe delay for every byte lane of a source-synchronous DRAM interface. The lanes need different delays because the clock and control wiring reaches each memory device at a different time. After a start pulse, the controller works through the lanes one at a time, in ascending order. For each lane it raises a delay-tap setting from zero by one step at a time. After every step it waits for the delay line and the memory's feedback to settle. It then takes several samples of that lane's feedback bit, which the memory produces by sampling its own clock with the incoming strobe.

The feedback arrives with no timing relation to the controller clock, so it passes through a two-flop synchronizer first. A majority vote over the samples at one tap gives a single value for that tap. The lane's calibrated tap is the first tap whose vote is one while the vote at the tap before it was zero. That tap is the point where strobe and clock line up at the memory. The result is kept per lane so that the data and strobe launch timing can later be offset from it. If a lane reaches its last tap without such a rise, its error bit is set and its result becomes the maximum tap.

Top module: `wl_calib_ctrl`

## Requirements
- R1: After reset, busy_o and done_o are 0, every result field and error bit is 0, and every tap_o field is 0.
- R2: A start_i pulse seen while idle clears all results and error bits in the same clock edge and raises busy_o on that edge. Calibration then begins on lane 0 at tap 0. While a lane is being swept, its tap only ever rises by exactly 1.
- R3: Each lane's feedback passes through a two-flop synchronizer. Per tap, the controller spends settle_cycles_i+1 settle cycles, then VOTES sample cycles, then 1 decision cycle. A lane whose result is E keeps busy_o high for (E+1)*(settle+VOTES+2)+1 cycles, the last being the lane-advance cycle. settle_cycles_i is captured at start and must be 2 or more.
- R4: The value at a tap is the majority of its VOTES synchronized samples (VOTES=3). Isolated one-cycle highs in the feedback, no more than one in any three consecutive cycles, give a vote of 0.
- R5: A lane's result is the lowest tap t ≥ 1 whose vote is 1 while the vote at t-1 was 0. Tap 0 can never be a result. A run of ones at the low taps is skipped until a zero has been seen.
- R6: If a lane reaches tap 2^TAP_W-1 (63) without the rise of R5, its error bit is set and its result is 63. A rise found exactly at tap 63 gives result 63 with no error.
- R7: Lanes are calibrated in ascending order. The tap and result of lane l sit at bits [l*TAP_W +: TAP_W], and error bit l belongs to lane l. The lane under calibration drives its live tap on tap_o. Every other lane drives its stored result, so lower lanes are final and higher lanes read 0 while a lane sweeps.
- R8: done_o is a one-cycle pulse, given in the cycle right after busy_o falls, when every lane is finished.
- R9: start_i while busy_o is high is ignored: results, timing and the done pulse are unchanged.
- R10: Each lane is judged only on its own feedback bit fb_i[l], so lanes with different feedback patterns get independent results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| settle_cycles_i | input | SETTLE_W | Settle wait after each tap change, captured at start |
| fb_i | input | LANES | Asynchronous clock-sample feedback, one bit per lane |
| tap_o | output | LANES*TAP_W | Per-lane strobe delay tap setting |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle pulse when all lanes are finished |
| result_o | output | LANES*TAP_W | Per-lane calibrated tap |
| error_o | output | LANES | Per-lane flag: no rising edge found |

## Verification
The hardest situation to reach is a feedback bit that flickers near the edge. Getting there requires glitches that land inside the sampling window of one particular tap, while the tap itself moves only under the controller's control. The bench closes the loop with a memory model: every lane's feedback is computed from that lane's own tap_o. The model places brief, sparse highs on the tap just below the edge, from a free-running phase counter, so that whatever the alignment, at most one high falls inside any three-sample window. Other feedback patterns cover a high run at the low taps, feedback stuck at 0 or at 1, and an edge at the last tap. In those patterns the decision logic must skip a false start, fall back to the error path, or accept the very last tap.

// File: rtl/wl_pkg.sv
package wl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_DECIDE,
        ST_ADVANCE,
        ST_FINISH
    } wl_state_e;
endpackage

// File: rtl/wl_sync.sv
module wl_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/wl_vote.sv
module wl_vote #(
    parameter int VOTES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic bit_i,
    output logic maj_o
);
    localparam int CNT_W = $clog2(VOTES + 1);

    logic [CNT_W-1:0] ones_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (clr_i) begin
            ones_q <= '0;
        end else if (en_i && bit_i) begin
            ones_q <= ones_q + 1'b1;
        end
    end

    assign maj_o = (ones_q > CNT_W'(VOTES / 2));
endmodule

// File: rtl/wl_result_bank.sv
module wl_result_bank #(
    parameter int LANES = 4,
    parameter int TAP_W = 6
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    clr_i,
    input  logic                                    we_i,
    input  logic [(LANES > 1 ? $clog2(LANES) : 1)-1:0] lane_i,
    input  logic [TAP_W-1:0]                        val_i,
    input  logic                                    err_i,
    output logic [LANES*TAP_W-1:0]                  res_o,
    output logic [LANES-1:0]                        err_o
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [TAP_W-1:0] res_q;
        logic             err_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
                err_q <= 1'b0;
            end else if (clr_i) begin
                res_q <= '0;
                err_q <= 1'b0;
            end else if (we_i && lane_i == LANE_W'(l)) begin
                res_q <= val_i;
                err_q <= err_i;
            end
        end

        assign res_o[l*TAP_W +: TAP_W] = res_q;
        assign err_o[l]                = err_q;
    end
endmodule

// File: rtl/wl_calib_ctrl.sv
module wl_calib_ctrl
    import wl_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int TAP_W    = 6,
    parameter int SETTLE_W = 8,
    parameter int VOTES    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [SETTLE_W-1:0]    settle_cycles_i,
    input  logic [LANES-1:0]       fb_i,
    output logic [LANES*TAP_W-1:0] tap_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [LANES*TAP_W-1:0] result_o,
    output logic [LANES-1:0]       error_o
);
    localparam int               LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int               SAMP_W  = $clog2(VOTES + 1);
    localparam logic [TAP_W-1:0] MAX_TAP = {TAP_W{1'b1}};
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    wl_state_e state_q, state_d;

    logic [LANE_W-1:0]   lane_q;
    logic [TAP_W-1:0]    tap_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [SETTLE_W-1:0] wait_q;
    logic [SAMP_W-1:0]   samp_q;
    logic                prev_bit_q;
    logic                prev_ok_q;

    logic [LANES-1:0] fb_sync;
    logic             fb_sel;
    logic             maj;
    logic             rise_hit;
    logic             at_max;
    logic             lane_end;
    logic             accept;

    wl_sync #(.WIDTH(LANES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(fb_i),
        .sync_o (fb_sync)
    );

    assign fb_sel = fb_sync[lane_q];

    wl_vote #(.VOTES(VOTES)) u_vote (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(state_q == ST_SETTLE),
        .en_i (state_q == ST_SAMPLE),
        .bit_i(fb_sel),
        .maj_o(maj)
    );

    assign rise_hit = prev_ok_q && !prev_bit_q && maj;
    assign at_max   = (tap_q == MAX_TAP);
    assign lane_end = rise_hit || at_max;
    assign accept   = (state_q == ST_IDLE) && start_i;

    wl_result_bank #(.LANES(LANES), .TAP_W(TAP_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (accept),
        .we_i  ((state_q == ST_DECIDE) && lane_end),
        .lane_i(lane_q),
        .val_i (tap_q),
        .err_i (!rise_hit),
        .res_o (result_o),
        .err_o (error_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_SETTLE;
            ST_SETTLE:  if (wait_q == '0) state_d = ST_SAMPLE;
            ST_SAMPLE:  if (samp_q == SAMP_W'(VOTES - 1)) state_d = ST_DECIDE;
            ST_DECIDE:  state_d = lane_end ? ST_ADVANCE : ST_SETTLE;
            ST_ADVANCE: state_d = (lane_q == LAST_LANE) ? ST_FINISH : ST_SETTLE;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // sweep datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q     <= '0;
            tap_q      <= '0;
            settle_q   <= '0;
            wait_q     <= '0;
            samp_q     <= '0;
            prev_bit_q <= 1'b0;
            prev_ok_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        lane_q    <= '0;
                        tap_q     <= '0;
                        prev_ok_q <= 1'b0;
                        settle_q  <= settle_cycles_i;
                        wait_q    <= settle_cycles_i;
                    end
                end
                ST_SETTLE: begin
                    samp_q <= '0;
                    if (wait_q != '0) wait_q <= wait_q - 1'b1;
                end
                ST_SAMPLE: begin
                    samp_q <= samp_q + 1'b1;
                end
                ST_DECIDE: begin
                    if (!lane_end) begin
                        tap_q      <= tap_q + 1'b1;
                        prev_bit_q <= maj;
                        prev_ok_q  <= 1'b1;
                        wait_q     <= settle_q;
                    end
                end
                ST_ADVANCE: begin
                    if (lane_q != LAST_LANE) begin
                        lane_q    <= lane_q + 1'b1;
                        tap_q     <= '0;
                        prev_ok_q <= 1'b0;
                        wait_q    <= settle_q;
                    end
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o = (state_q != ST_IDLE) && (state_q != ST_FINISH);
        done_o = (state_q == ST_FINISH);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_tap
        assign tap_o[l*TAP_W +: TAP_W] =
            (busy_o && lane_q == LANE_W'(l)) ? tap_q : result_o[l*TAP_W +: TAP_W];
    end
endmodule

module wl_calib_checker #(
    parameter int LANES = 4,
    parameter int TAP_W = 6
) (
    input logic                                    clk,
    input logic                                    rst_n,
    input logic                                    start_i,
    input logic                                    busy_o,
    input logic                                    done_o,
    input logic [LANES*TAP_W-1:0]                  result_o,
    input logic [LANES-1:0]                        error_o,
    input logic [TAP_W-1:0]                        tap_q,
    input logic [(LANES > 1 ? $clog2(LANES) : 1)-1:0] lane_q
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r2_tap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && lane_q == $past(lane_q) && tap_q != $past(tap_q))
            |-> tap_q == TAP_W'($past(tap_q) + 1'b1));

    a_r7_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && lane_q != $past(lane_q))
            |-> lane_q == LANE_W'($past(lane_q) + 1'b1));

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o && start_i) |=> (busy_o && result_o == '0 && error_o == '0));

    for (genvar l = 0; l < LANES; l++) begin : g_err
        a_r6_err_max: assert property (@(posedge clk) disable iff (!rst_n)
            error_o[l] |-> result_o[l*TAP_W +: TAP_W] == {TAP_W{1'b1}});
    end
endmodule

bind wl_calib_ctrl wl_calib_checker #(.LANES(LANES), .TAP_W(TAP_W)) u_wl_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .result_o(result_o),
    .error_o (error_o),
    .tap_q   (tap_q),
    .lane_q  (lane_q)
);

// File: tb/wl_calib_ctrl_bench.sv
module wl_calib_ctrl_bench;
    localparam int LANES    = 4;
    localparam int TAP_W    = 6;
    localparam int SETTLE_W = 8;
    localparam int VOTES    = 3;
    localparam int MAXT     = (1 << TAP_W) - 1;

    typedef struct {
        int lane;
        int res;
        bit err;
    } exp_t;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start_i = 1'b0;
    logic [SETTLE_W-1:0]    settle_cycles_i = '0;
    logic [LANES-1:0]       fb_i;
    logic [LANES*TAP_W-1:0] tap_o;
    logic                   busy_o;
    logic                   done_o;
    logic [LANES*TAP_W-1:0] result_o;
    logic [LANES-1:0]       error_o;

    int edge_pos [LANES];
    int hi_until [LANES];
    int noise_at [LANES];
    int ncnt = 0;
    int tests = 0;
    int fails = 0;
    int busy_cnt = 0;
    int exp_busy = 0;
    int done_cnt = 0;
    int cycles = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    wl_calib_ctrl #(.LANES(LANES), .TAP_W(TAP_W), .SETTLE_W(SETTLE_W), .VOTES(VOTES)) u_wl_calib_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_cycles_i(settle_cycles_i),
        .fb_i(fb_i), .tap_o(tap_o), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .error_o(error_o)
    );

    function automatic int tap_of(int l);
        return int'(tap_o[l*TAP_W +: TAP_W]);
    endfunction

    function automatic int res_of(int l);
        return int'(result_o[l*TAP_W +: TAP_W]);
    endfunction

    // memory model: feedback from each lane's own tap
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            int t;
            t = int'(tap_o[l*TAP_W +: TAP_W]);
            if (t == noise_at[l])
                fb_i[l] = (ncnt == 0);
            else
                fb_i[l] = (t < hi_until[l]) || (edge_pos[l] >= 0 && t >= edge_pos[l]);
        end
    end

    always @(negedge clk) begin
        ncnt <= (ncnt + 1) % 4;
        cycles <= cycles + 1;
        if (busy_o) busy_cnt <= busy_cnt + 1;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit vote_at(int l, int t);
        if (t == noise_at[l]) return 1'b0;
        return (t < hi_until[l]) || (edge_pos[l] >= 0 && t >= edge_pos[l]);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (done_o) begin
            done_cnt++;
            check(busy_cnt == exp_busy, "R3", "busy cycles", busy_cnt, exp_busy);
            for (int k = 0; k < LANES; k++) begin
                exp_t e;
                if (sb.size() == 0) begin
                    check(1'b0, "R8", "unexpected done", 1, 0);
                    break;
                end
                e = sb.pop_front();
                check(res_of(e.lane) == e.res, "R5", $sformatf("lane %0d result", e.lane),
                      res_of(e.lane), e.res);
                check(error_o[e.lane] == e.err, "R6", $sformatf("lane %0d error", e.lane),
                      int'(error_o[e.lane]), int'(e.err));
            end
        end
    end

    task automatic timeout_end();
        check(1'b0, "WDOG", "watchdog expired", cycles, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // driver: push expectations, run one calibration
    task automatic run_case(int settle, bit mid_start, string name);
        int total;
        int d0;
        total = 0;
        for (int l = 0; l < LANES; l++) begin
            exp_t e;
            e.lane = l;
            e.res = MAXT;
            e.err = 1'b1;
            for (int t = 1; t <= MAXT; t++) begin
                if (!vote_at(l, t - 1) && vote_at(l, t)) begin
                    e.res = t;
                    e.err = 1'b0;
                    break;
                end
            end
            sb.push_back(e);
            total += (e.res + 1) * (settle + VOTES + 2) + 1;
        end
        d0 = done_cnt;
        @(negedge clk);
        settle_cycles_i = SETTLE_W'(settle);
        exp_busy = total;
        busy_cnt = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2", {name, " busy after start"}, int'(busy_o), 1);
        check(result_o == '0 && error_o == '0, "R2", {name, " results cleared"},
              int'(result_o), 0);
        check(tap_of(0) == 0, "R2", {name, " lane0 starts at tap 0"}, tap_of(0), 0);
        // order: lane0 final before lane1 sweeps, higher lanes still 0
        for (int w = 0; w < 100000 && tap_of(1) == 0; w++) @(negedge clk);
        if (tap_of(1) == 0) timeout_end();
        check(res_of(0) == sb[0].res, "R7", {name, " lane0 final before lane1"},
              res_of(0), sb[0].res);
        check(res_of(2) == 0 && res_of(3) == 0, "R7", {name, " upper lanes pending"},
              res_of(2) + res_of(3), 0);
        if (mid_start) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int w = 0; w < 100000 && done_cnt == d0; w++) @(negedge clk);
        if (done_cnt == d0) timeout_end();
        @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R8", {name, " done is one cycle"},
              int'(done_o), 0);
        check(sb.size() == 0, "R10", {name, " all lanes reported"}, sb.size(), 0);
    endtask

    task automatic set_lane(int l, int e, int hi, int nz);
        edge_pos[l] = e;
        hi_until[l] = hi;
        noise_at[l] = nz;
    endtask

    initial begin
        for (int l = 0; l < LANES; l++) set_lane(l, 5, 0, -1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy_o == 1'b0, "R1", "busy after reset", int'(busy_o), 0);
        check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
        check(result_o == '0, "R1", "results after reset", int'(result_o), 0);
        check(error_o == '0, "R1", "errors after reset", int'(error_o), 0);
        check(tap_o == '0, "R1", "taps after reset", int'(tap_o), 0);

        // R5 R10: distinct edges, edge at tap 1 and at last tap (R6)
        set_lane(0, 5, 0, -1); set_lane(1, 12, 0, -1);
        set_lane(2, 1, 0, -1); set_lane(3, MAXT, 0, -1);
        run_case(3, 1'b0, "edges");
        check(tap_of(3) == MAXT && error_o[3] == 1'b0, "R6", "edge at last tap",
              tap_of(3), MAXT);

        // R4: glitches just below the edge
        set_lane(0, 20, 0, 19); set_lane(1, 8, 0, 7);
        set_lane(2, 30, 0, 29); set_lane(3, 3, 0, 2);
        run_case(2, 1'b0, "noise");

        // R6: stuck low / stuck high
        set_lane(0, -1, 0, -1); set_lane(1, -1, 64, -1);
        set_lane(2, 10, 0, -1); set_lane(3, -1, 0, -1);
        run_case(5, 1'b0, "stuck");
        check(error_o == 4'b1011, "R6", "error vector", int'(error_o), 11);

        // R5: high run at low taps skipped
        set_lane(0, 9, 4, -1); set_lane(1, 2, 2, -1);
        set_lane(2, 6, 1, -1); set_lane(3, 40, 0, -1);
        run_case(3, 1'b0, "highrun");

        // R9: start while busy ignored
        set_lane(0, 7, 0, -1); set_lane(1, 7, 0, -1);
        set_lane(2, 7, 0, -1); set_lane(3, 7, 0, -1);
        run_case(4, 1'b1, "midstart");
        check(done_cnt == 5, "R9", "done count", done_cnt, 5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 190000);
        timeout_end();
    end
endmodule